// File: doc/BRIEF.md
# Marker-Coded Word Unpacker

The block takes 32-bit words in which one to four payload bytes are packed, and turns each word into a stream of single bytes, one per handshake, lowest byte first. The number of bytes a word carries is not sent alongside it. The block works it out from marker patterns in the upper byte lanes: a run of `0x80` bytes above bit 8 marks a single byte, `0x8181` in the top half marks two, `0x82` in the top byte marks three, and any other word carries a full four bytes.

Each word arrives with a 4-bit channel tag on a valid/ready input. The tag is captured with the word and repeated on every byte the word produces, so a downstream router can steer bytes without seeing the word. A flag on the output marks the final byte of each word. Only one word is held at a time. The input is refused until every byte of the held word has been taken.

Top module: `word_unpacker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block drops any held word. After that edge `out_valid` is 0 and `in_ready` is 1.
- R2: A word whose bits 31:8 equal `0x808080` yields exactly one byte, equal to bits 7:0.
- R3: A word whose bits 31:16 equal `0x8181` (and which does not match R2) yields two bytes: bits 7:0, then bits 15:8.
- R4: A word whose bits 31:24 equal `0x82` (and which does not match R2 or R3) yields three bytes: bits 7:0, bits 15:8, then bits 23:16.
- R5: Any other word yields four bytes, including near misses such as `0x80808100` or `0x8180xxxx`. The checks are tried in the order R2, then R3, then R4.
- R6: The bytes of a word leave in ascending lane order, starting with bits 7:0.
- R7: `in_ready` is 0 from the edge that accepts a word until the edge at which its last byte is taken. In the cycle after that edge, `in_ready` is 1 and `out_valid` is 0.
- R8: Every byte of a word carries, on `out_chan`, the tag that was on `in_chan` when the word was accepted.
- R9: `out_last` is 1 on the final byte of each word and 0 on every other byte.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_byte`, `out_chan`, `out_last` and `out_valid` hold their values into the next cycle.
- R11: The first byte of a word is presented with `out_valid` high in the cycle after the edge that accepts the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 32 | Packed word |
| in_chan | input | CHAN_W (4) | Channel tag of the word |
| out_valid | output | 1 | A byte is presented |
| out_ready | input | 1 | Consumer takes the byte |
| out_byte | output | 8 | Current byte |
| out_chan | output | CHAN_W (4) | Tag of the word the byte came from |
| out_last | output | 1 | Byte is the final one of its word |

## Verification
A word offered with `in_ready` high is taken at the next rising edge. Its first byte is due in the cycle after that edge, and each later byte is due in the cycle after the edge that takes the one before it. So one word of N bytes occupies the block for N handshakes, and `in_ready` returns in the cycle after the last of them.

The bench drives its inputs and samples the outputs on falling edges, one sample per cycle, so every sample falls in the cycle where the next result is due. It stalls `out_ready` at random and compares the presented byte, tag and last flag on every cycle, stalled or not, against the lane the bench's own length model expects. In the cycle after each word's last handshake it confirms that `in_ready` is 1 and `out_valid` is 0.

// File: rtl/unpack_pkg.sv
// Package: widths, marker constants and the length classifier shared by the
// unpacker modules. Assumes a word of LANES lanes of BYTE_W bits each.
package unpack_pkg;
    parameter int BYTE_W = 8;
    parameter int LANES  = 4;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int IDX_W  = $clog2(LANES);

    typedef logic [IDX_W-1:0]  lane_idx_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam logic [BYTE_W-1:0] MARK_ONE   = 8'h80;
    localparam logic [BYTE_W-1:0] MARK_TWO   = 8'h81;
    localparam logic [BYTE_W-1:0] MARK_THREE = 8'h82;

    // Returns the index of the last payload lane (byte count minus one).
    // Priority: one-byte marker, then two-byte, then three-byte.
    function automatic lane_idx_t last_lane(input word_t w);
        if (w[WORD_W-1:BYTE_W] == {3{MARK_ONE}})
            return lane_idx_t'(0);
        else if (w[WORD_W-1:2*BYTE_W] == {2{MARK_TWO}})
            return lane_idx_t'(1);
        else if (w[WORD_W-1:3*BYTE_W] == MARK_THREE)
            return lane_idx_t'(2);
        else
            return lane_idx_t'(LANES-1);
    endfunction
endpackage

// File: rtl/unpack_len_decode.sv
// Length decoder: classifies an incoming word by its marker bytes and gives
// the index of its last payload lane. Purely combinational.
module unpack_len_decode
    import unpack_pkg::*;
(
    input  word_t     word_i,
    output lane_idx_t last_o
);
    // Classify the word; the ordering lives in the package function.
    always_comb last_o = last_lane(word_i);
endmodule

// File: rtl/unpack_lane_mux.sv
// Lane selector: picks one BYTE_W lane out of a word by index. Assumes the
// index is always below LANES.
module unpack_lane_mux #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [BYTE_W*LANES-1:0] word_i,
    input  logic [IDX_W-1:0]        sel_i,
    output logic [BYTE_W-1:0]       byte_o
);
    logic [BYTE_W-1:0] lane [LANES];

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            // Slice lane g out of the word.
            assign lane[g] = word_i[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    // Route the selected lane to the output.
    always_comb byte_o = lane[sel_i];
endmodule

// File: rtl/unpack_seq.sv
// Sequencer: holds one word, its tag and its last-lane index, and steps a
// lane pointer once per output handshake. Assumes load and adv never coincide
// (load needs the block idle, adv needs it busy).
module unpack_seq
    import unpack_pkg::*;
#(
    parameter int CHAN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    input  word_t             word_i,
    input  logic [CHAN_W-1:0] chan_i,
    input  lane_idx_t         last_i,
    output logic              busy_o,
    output word_t             word_o,
    output logic [CHAN_W-1:0] chan_o,
    output lane_idx_t         idx_o,
    output logic              at_last_o
);
    lane_idx_t last_q;

    // Capture a word on load, advance or release it on each output handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            word_o <= '0;
            chan_o <= '0;
            idx_o  <= '0;
            last_q <= '0;
        end else if (load_i) begin
            busy_o <= 1'b1;
            word_o <= word_i;
            chan_o <= chan_i;
            idx_o  <= '0;
            last_q <= last_i;
        end else if (adv_i) begin
            if (at_last_o) busy_o <= 1'b0;
            else           idx_o  <= idx_o + lane_idx_t'(1);
        end
    end

    // The pointer has reached the word's final lane.
    always_comb at_last_o = (idx_o == last_q);
endmodule

// File: rtl/word_unpacker.sv
// Top: accepts one marker-coded word at a time and emits its payload bytes
// lowest lane first, each tagged with the word's channel; flags the last.
// Assumes the consumer honours valid/ready; nothing is buffered beyond one word.
module word_unpacker
    import unpack_pkg::*;
#(
    parameter int CHAN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_word,
    input  logic [CHAN_W-1:0] in_chan,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_byte,
    output logic [CHAN_W-1:0] out_chan,
    output logic              out_last
);
    lane_idx_t         dec_last;
    logic              busy;
    logic              at_last;
    logic              load;
    logic              adv;
    word_t             held_word;
    lane_idx_t         idx;

    unpack_len_decode u_dec (
        .word_i (in_word),
        .last_o (dec_last)
    );

    // Handshakes on both sides.
    always_comb begin
        in_ready  = !busy;
        load      = in_valid && in_ready;
        out_valid = busy;
        adv       = out_valid && out_ready;
        out_last  = busy && at_last;
    end

    unpack_seq #(.CHAN_W(CHAN_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .adv_i     (adv),
        .word_i    (in_word),
        .chan_i    (in_chan),
        .last_i    (dec_last),
        .busy_o    (busy),
        .word_o    (held_word),
        .chan_o    (out_chan),
        .idx_o     (idx),
        .at_last_o (at_last)
    );

    unpack_lane_mux #(.BYTE_W(BYTE_W), .LANES(LANES)) u_mux (
        .word_i (held_word),
        .sel_i  (idx),
        .byte_o (out_byte)
    );
endmodule

// File: rtl/unpack_chk.sv
// Checker: temporal properties of the unpacker's ports, bound to the top.
module unpack_chk #(
    parameter int CHAN_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [31:0]       in_word,
    input logic [CHAN_W-1:0] in_chan,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_byte,
    input logic [CHAN_W-1:0] out_chan,
    input logic              out_last
);
    logic [1:0] nbytes;

    // Counts bytes already taken from the current word.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     nbytes <= '0;
        else if (in_valid && in_ready)                  nbytes <= '0;
        else if (out_valid && out_ready && !out_last)   nbytes <= nbytes + 2'd1;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid && in_ready);

    // R11
    first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && out_byte == $past(in_word[7:0])
                                 && out_chan == $past(in_chan));

    // R2
    single_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_word[31:8] == 24'h808080 |=> out_last);

    // R10
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_byte)
                                    && $stable(out_chan) && $stable(out_last));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> in_ready && !out_valid);

    // R9
    max_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && nbytes == 2'd3 |-> out_last);
endmodule

bind word_unpacker unpack_chk #(.CHAN_W(CHAN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_word   (in_word),
    .in_chan   (in_chan),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte),
    .out_chan  (out_chan),
    .out_last  (out_last)
);

// File: tb/sim_word_unpacker.sv
module sim_word_unpacker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic [3:0]  in_chan = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_byte;
    logic [3:0]  out_chan;
    logic        out_last;

    int compared = 0;
    int mismatched = 0;

    always #2 clk = ~clk;

    word_unpacker #(.CHAN_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .in_chan(in_chan), .out_valid(out_valid),
        .out_ready(out_ready), .out_byte(out_byte), .out_chan(out_chan),
        .out_last(out_last)
    );

    // Expected byte count, from the marker rules alone.
    function automatic int exp_count(input logic [31:0] w);
        if (w[31:8] == 24'h808080) return 1;
        if (w[31:16] == 16'h8181)  return 2;
        if (w[31:24] == 8'h82)     return 3;
        return 4;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Offer one word, then drain it with the given stall percentage.
    task automatic run_word(input logic [31:0] w, input logic [3:0] ch, input int stall_pct);
        int n = exp_count(w);
        int i = 0;
        @(negedge clk);
        in_valid = 1'b1; in_word = w; in_chan = ch; out_ready = 1'b0;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        // R11: first byte is up in the cycle after acceptance.
        check("R11 valid after accept", 32'(out_valid), 32'd1);
        while (i < n) begin
            out_ready = (($urandom % 100) >= stall_pct);
            check("R7 in_ready low while busy", 32'(in_ready), 32'd0);
            // R6 R2 R3 R4 R5: lane i in ascending order; R10 held while stalled.
            check(n == 1 ? "R2 byte" : n == 2 ? "R3 byte" : n == 3 ? "R4 byte" : "R5 R6 byte",
                  32'(out_byte), 32'(w[8*i +: 8]));
            check("R8 channel", 32'(out_chan), 32'(ch));
            check("R9 last flag", 32'(out_last), 32'(i == n-1));
            check("R10 valid held", 32'(out_valid), 32'd1);
            @(negedge clk);
            if (out_ready) i++;
        end
        out_ready = 1'b0;
        check("R7 ready after last", 32'(in_ready), 32'd1);
        check("R7 idle after last", 32'(out_valid), 32'd0);
    endtask

    function automatic logic [31:0] pick_word();
        logic [31:0] r = $urandom;
        case ($urandom % 5)
            0: return {24'h808080, r[7:0]};
            1: return {16'h8181, r[15:0]};
            2: return {8'h82, r[23:0]};
            3: return r;
            default: case ($urandom % 4)
                0: return {24'h808081, r[7:0]};
                1: return {16'h8180, r[15:0]};
                2: return {8'h83, r[23:0]};
                default: return {16'h8080, r[15:0]};
            endcase
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1 valid in reset", 32'(out_valid), 32'd0);
        check("R1 ready in reset", 32'(in_ready), 32'd1);
        rst_n = 1'b1;

        // Directed corners.
        run_word(32'h808080A5, 4'h3, 0);   // R2
        run_word(32'h80808080, 4'h0, 50);  // R2 payload equals marker
        run_word(32'h81813C4D, 4'hF, 30);  // R3
        run_word(32'h81818080, 4'h1, 0);   // R3
        run_word(32'h82112233, 4'h7, 60);  // R4
        run_word(32'h82818181, 4'h2, 0);   // R4 with lower marker-like bytes
        run_word(32'h80808100, 4'h9, 0);   // R5 near miss
        run_word(32'h8180FFEE, 4'hA, 40);  // R5 near miss
        run_word(32'h12345678, 4'h5, 0);   // R5 R6

        // R1: reset mid-word drops it.
        @(negedge clk);
        in_valid = 1'b1; in_word = 32'hDEADBEEF; in_chan = 4'h4;
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 word dropped valid", 32'(out_valid), 32'd0);
        check("R1 word dropped ready", 32'(in_ready), 32'd1);

        // Constrained random words.
        for (int k = 0; k < 400; k++) begin
            logic [31:0] w = pick_word();
            logic [31:0] c = $urandom;
            run_word(w, c[3:0], int'($urandom % 70));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule